// File: doc/BRIEF.md
# Configuration Address/Data Access Decoder

This block sits behind a host I/O port and converts configuration-space accesses into register transactions toward an array of targets. The host first stores a 32-bit configuration address in an address latch port. It then reads or writes a four-byte data window port. Each data-window access is decoded against the latched address to find a bus number, a device number, a function number and a register offset. The block then issues a single-cycle read or write strobe, with byte enables, to the selected target.

Accesses are refused in three cases: the latched address is not enabled, its low two bits are not zero, or the external target map reports that no target is present. A refused write leaves every target untouched, and a refused read returns zero. Every read, whether of the latch or of the data window, gets its response one cycle later on a registered data bus with a one-cycle valid pulse.

Top module: `cfgAccessDecoder`

## Requirements
- R1: A write of size code 2 or 3 (dword) to the address port (`hostSel`=0) stores `hostWdata` in the latch. A dword read of the address port returns the latch. An address-port write of size code 0 (byte) or 1 (word) leaves the latch unchanged, and an address-port read of those sizes returns zero.
- R2: The latch resets to zero, so data-window accesses after reset issue no strobe, and reads of the window return zero until bit 31 has been set.
- R3: While latch bit 31 is clear, data-window accesses (`hostSel`=1) raise neither `tgtRd` nor `tgtWr`, and their reads return zero.
- R4: While latch bits 1:0 are nonzero, data-window accesses raise no strobe, and their reads return zero.
- R5: The decoded target fields are as follows. `tgtBus` is latch bits 23:16. `tgtDev` is latch bits 15:11. `tgtFunc` is latch bits 10:8. `tgtReg` is latch bits 7:2 followed by `hostOfs` as its bits 1:0.
- R6: A data-window access made while `tgtPresent` is low in the same cycle raises no strobe, and its read returns zero.
- R7: Size code 0 selects one byte, code 1 two bytes, and codes 2 and 3 four bytes. `tgtBe` is the size mask shifted left by `hostOfs` and truncated to 4 bits. `tgtWdata` is `hostWdata` shifted left by 8×`hostOfs`.
- R8: On the cycle after any read, `hostRvalid` is high for one cycle. For an accepted data read, `hostRdata` holds `tgtRdata` shifted right by 8×`hostOfs`, with bytes beyond the access size cleared. `hostRvalid` stays low after writes and idle cycles.
- R9: `tgtRd` and `tgtWr` are combinational in the access cycle only. They are never high together, and they are low when `hostValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostValid | input | 1 | Host access in this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSel | input | 1 | 0 = address port, 1 = data window |
| hostOfs | input | 2 | Byte offset of the access within the port |
| hostSize | input | 2 | Size code: 0 byte, 1 word, 2/3 dword |
| hostWdata | input | 32 | Host write data, addressed byte at bit 0 |
| hostRdata | output | 32 | Registered read response |
| hostRvalid | output | 1 | Read response valid pulse |
| tgtBus | output | 8 | Decoded bus number |
| tgtDev | output | 5 | Decoded device number |
| tgtFunc | output | 3 | Decoded function number |
| tgtReg | output | 8 | Decoded register byte offset |
| tgtPresent | input | 1 | Target exists at the decoded bus/device/function |
| tgtRd | output | 1 | Read strobe to the target |
| tgtWr | output | 1 | Write strobe to the target |
| tgtBe | output | 4 | Byte enables in dword lane order |
| tgtWdata | output | 32 | Lane-aligned write data |
| tgtRdata | input | 32 | Target dword read data, same cycle as `tgtRd` |

## Verification
Two functions can fall in the same cycle: the legality check on the latched address, and the target-present test against the external map. A read can be refused by either of them, and in both cases it must still produce a valid pulse carrying zero. The bench provokes each refusal on its own, holding the other condition satisfied. It judges the result on the strobes in the access cycle and on the response bus one cycle later. It also drives partial-width reads at the upper lane offsets, where the byte enables are truncated, and checks that the lane shift and size mask agree with the enables.

// File: rtl/cfgAccPkg.sv
package cfgAccPkg;
  localparam int DATA_BYTES = 4;
  localparam int DATA_W     = DATA_BYTES * 8;
  localparam int OFS_W      = $clog2(DATA_BYTES);

  // latch field positions; targets decode them
  localparam int ENABLE_BIT = 31;
  localparam int BUS_LSB    = 16;
  localparam int BUS_W      = 8;
  localparam int DEV_LSB    = 11;
  localparam int DEV_W      = 5;
  localparam int FUNC_LSB   = 8;
  localparam int FUNC_W     = 3;
  localparam int REG_W      = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_DWALT = 2'd3
  } accSize_t;

  typedef struct packed {
    logic latchWr;
    logic issueRd;
    logic issueWr;
    logic rspLoad;
    logic rspAddr;
    logic rspZero;
  } ctrlStrobes_t;
endpackage

// File: rtl/cfgCtrl.sv
module cfgCtrl
  import cfgAccPkg::*;
(
  input  logic         hostValid,
  input  logic         hostWrite,
  input  logic         hostSel,
  input  logic [1:0]   hostSize,
  input  logic         addrEnable,
  input  logic         addrLowZero,
  input  logic         tgtPresent,
  output ctrlStrobes_t strobes
);
  logic isDword;
  logic addrAcc;
  logic dataAcc;
  logic dataOk;

  assign isDword = (hostSize == SZ_DWORD) || (hostSize == SZ_DWALT);
  assign addrAcc = hostValid && !hostSel;
  assign dataAcc = hostValid && hostSel;
  assign dataOk  = addrEnable && addrLowZero && tgtPresent;

  always_comb begin
    strobes         = '0;
    strobes.latchWr = addrAcc && hostWrite && isDword;
    strobes.issueRd = dataAcc && !hostWrite && dataOk;
    strobes.issueWr = dataAcc && hostWrite && dataOk;
    strobes.rspLoad = hostValid && !hostWrite;
    strobes.rspAddr = !hostSel;
    strobes.rspZero = hostSel ? !dataOk : !isDword;
  end
endmodule

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import cfgAccPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [OFS_W-1:0]  hostOfs,
  input  logic [1:0]        hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] tgtRdata,
  output logic              addrEnable,
  output logic              addrLowZero,
  output logic [BUS_W-1:0]  tgtBus,
  output logic [DEV_W-1:0]  tgtDev,
  output logic [FUNC_W-1:0] tgtFunc,
  output logic [REG_W-1:0]  tgtReg,
  output logic [DATA_BYTES-1:0] tgtBe,
  output logic [DATA_W-1:0] tgtWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid
);
  localparam int SHIFT_W = OFS_W + 3;

  logic [DATA_W-1:0]     addrLatch;
  logic [DATA_BYTES-1:0] sizeMask;
  logic [DATA_W-1:0]     rdShifted;
  logic [DATA_W-1:0]     rdMasked;
  logic [SHIFT_W-1:0]    laneShift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               addrLatch <= '0;
    else if (strobes.latchWr) addrLatch <= hostWdata;
  end

  assign addrEnable  = addrLatch[ENABLE_BIT];
  assign addrLowZero = (addrLatch[OFS_W-1:0] == '0);
  assign tgtBus      = addrLatch[BUS_LSB +: BUS_W];
  assign tgtDev      = addrLatch[DEV_LSB +: DEV_W];
  assign tgtFunc     = addrLatch[FUNC_LSB +: FUNC_W];
  assign tgtReg      = {addrLatch[REG_W-1:OFS_W], hostOfs};

  assign laneShift = {hostOfs, 3'b000};
  assign rdShifted = tgtRdata >> laneShift;
  assign tgtWdata  = hostWdata << laneShift;
  assign tgtBe     = sizeMask << hostOfs;

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
    assign sizeMask[b]          = (b < (32'd1 << hostSize));
    assign rdMasked[b*8 +: 8]   = sizeMask[b] ? rdShifted[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hostRdata  <= '0;
      hostRvalid <= 1'b0;
    end else begin
      hostRvalid <= strobes.rspLoad;
      if (strobes.rspLoad)
        hostRdata <= strobes.rspZero ? '0 : (strobes.rspAddr ? addrLatch : rdMasked);
    end
  end

  p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.latchWr |=> $stable(addrLatch));

  p_refused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.rspLoad && !strobes.rspAddr && !addrEnable) |=> (hostRdata == '0));
endmodule

// File: rtl/cfgAccessDecoder.sv
module cfgAccessDecoder
  import cfgAccPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hostValid,
  input  logic        hostWrite,
  input  logic        hostSel,
  input  logic [1:0]  hostOfs,
  input  logic [1:0]  hostSize,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostRvalid,
  output logic [7:0]  tgtBus,
  output logic [4:0]  tgtDev,
  output logic [2:0]  tgtFunc,
  output logic [7:0]  tgtReg,
  input  logic        tgtPresent,
  output logic        tgtRd,
  output logic        tgtWr,
  output logic [3:0]  tgtBe,
  output logic [31:0] tgtWdata,
  input  logic [31:0] tgtRdata
);
  ctrlStrobes_t strobes;
  logic addrEnable;
  logic addrLowZero;

  cfgCtrl u_ctrl (
    .hostValid  (hostValid),
    .hostWrite  (hostWrite),
    .hostSel    (hostSel),
    .hostSize   (hostSize),
    .addrEnable (addrEnable),
    .addrLowZero(addrLowZero),
    .tgtPresent (tgtPresent),
    .strobes    (strobes)
  );

  cfgDatapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .hostOfs    (hostOfs),
    .hostSize   (hostSize),
    .hostWdata  (hostWdata),
    .tgtRdata   (tgtRdata),
    .addrEnable (addrEnable),
    .addrLowZero(addrLowZero),
    .tgtBus     (tgtBus),
    .tgtDev     (tgtDev),
    .tgtFunc    (tgtFunc),
    .tgtReg     (tgtReg),
    .tgtBe      (tgtBe),
    .tgtWdata   (tgtWdata),
    .hostRdata  (hostRdata),
    .hostRvalid (hostRvalid)
  );

  assign tgtRd = strobes.issueRd;
  assign tgtWr = strobes.issueWr;

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tgtRd && tgtWr));

  p_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hostValid |-> !(tgtRd || tgtWr));

  p_rvalid_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hostValid && !hostWrite) |=> hostRvalid);

  p_rvalid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hostValid && !hostWrite) |=> !hostRvalid);

  p_absent_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hostValid && hostSel && !hostWrite && !tgtPresent) |=> (hostRdata == 32'h0));

  p_be_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgtRd || tgtWr) |-> (tgtBe != 4'h0));
endmodule

// File: tb/cfgAccessDecoder_test.sv
`timescale 1ns/1ps
module cfgAccessDecoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostValid = 1'b0, hostWrite = 1'b0, hostSel = 1'b0;
  logic [1:0]  hostOfs = '0, hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostRvalid;
  logic [7:0]  tgtBus, tgtReg;
  logic [4:0]  tgtDev;
  logic [2:0]  tgtFunc;
  logic        tgtPresent = 1'b1;
  logic        tgtRd, tgtWr;
  logic [3:0]  tgtBe;
  logic [31:0] tgtWdata;
  logic [31:0] tgtRdata = 32'hA1B2C3D4;

  int checks = 0;
  int errors = 0;

  // captured per access
  logic        cRd, cWr, cRdAfter, cWrAfter, cRv;
  logic [3:0]  cBe;
  logic [31:0] cWd, cRdata;

  always #5 clk = ~clk;

  cfgAccessDecoder uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic sel, input logic wr, input logic [1:0] ofs,
                     input logic [1:0] size, input logic [31:0] wd);
    @(negedge clk);
    hostValid = 1'b1; hostSel = sel; hostWrite = wr;
    hostOfs = ofs; hostSize = size; hostWdata = wd;
    #1;
    cRd = tgtRd; cWr = tgtWr; cBe = tgtBe; cWd = tgtWdata;
    @(posedge clk);
    #1;
    hostValid = 1'b0;
    #1;
    cRv = hostRvalid; cRdata = hostRdata; cRdAfter = tgtRd; cWrAfter = tgtWr;
  endtask

  task automatic setAddr(input logic [31:0] a);
    acc(1'b0, 1'b1, 2'd0, 2'd2, a);
  endtask

  task automatic testReset;
    chk(hostRvalid == 1'b0, "R8 reset rvalid", {31'd0, hostRvalid}, 32'd0);
    acc(1'b0, 1'b0, 2'd0, 2'd2, 0);
    chk(cRv && cRdata == 32'h0, "R2 latch reset", cRdata, 32'h0);
    acc(1'b1, 1'b0, 2'd0, 2'd2, 0);
    chk(!cRd && cRdata == 32'h0, "R2 window closed after reset", cRdata, 32'h0);
  endtask

  task automatic testAddrPort;
    setAddr(32'h80123A08);
    chk(!cRv, "R8 no rvalid on write", {31'd0, cRv}, 32'd0);
    acc(1'b0, 1'b0, 2'd0, 2'd2, 0);
    chk(cRv && cRdata == 32'h80123A08, "R1 latch readback", cRdata, 32'h80123A08);
    acc(1'b0, 1'b1, 2'd0, 2'd1, 32'hFFFF_FFFF);
    acc(1'b0, 1'b0, 2'd0, 2'd3, 0);
    chk(cRdata == 32'h80123A08, "R1 word write ignored", cRdata, 32'h80123A08);
    acc(1'b0, 1'b0, 2'd0, 2'd0, 0);
    chk(cRv && cRdata == 32'h0, "R1 byte read of latch is zero", cRdata, 32'h0);
  endtask

  task automatic testDecode;
    @(negedge clk);
    hostOfs = 2'd2;
    #1;
    chk(tgtBus == 8'h12, "R5 bus", {24'd0, tgtBus}, 32'h12);
    chk(tgtDev == 5'd7, "R5 device", {27'd0, tgtDev}, 32'd7);
    chk(tgtFunc == 3'd2, "R5 function", {29'd0, tgtFunc}, 32'd2);
    chk(tgtReg == 8'h0A, "R5 register", {24'd0, tgtReg}, 32'h0A);
  endtask

  task automatic testReads;
    acc(1'b1, 1'b0, 2'd0, 2'd2, 0);
    chk(cRd && !cWr && cBe == 4'hF, "R7 dword read be", {28'd0, cBe}, 32'hF);
    chk(cRv && cRdata == 32'hA1B2C3D4, "R8 dword read", cRdata, 32'hA1B2C3D4);
    chk(!cRdAfter && !cWrAfter, "R9 strobe drops", {31'd0, cRdAfter}, 32'd0);
    acc(1'b1, 1'b0, 2'd2, 2'd0, 0);
    chk(cBe == 4'b0100, "R7 byte be ofs2", {28'd0, cBe}, 32'h4);
    chk(cRdata == 32'h000000B2, "R8 byte read ofs2", cRdata, 32'hB2);
    acc(1'b1, 1'b0, 2'd1, 2'd1, 0);
    chk(cBe == 4'b0110, "R7 word be ofs1", {28'd0, cBe}, 32'h6);
    chk(cRdata == 32'h0000B2C3, "R8 word read ofs1", cRdata, 32'hB2C3);
    acc(1'b1, 1'b0, 2'd3, 2'd1, 0);
    chk(cBe == 4'b1000, "R7 word be ofs3 truncated", {28'd0, cBe}, 32'h8);
    chk(cRdata == 32'h000000A1, "R8 word read ofs3", cRdata, 32'hA1);
  endtask

  task automatic testWrite;
    acc(1'b1, 1'b1, 2'd3, 2'd0, 32'h0000005A);
    chk(cWr && !cRd, "R9 write strobe only", {30'd0, cWr, cRd}, 32'h2);
    chk(cBe == 4'b1000, "R7 byte write be", {28'd0, cBe}, 32'h8);
    chk(cWd[31:24] == 8'h5A, "R7 write lane", cWd, 32'h5A000000);
    chk(!cRv, "R8 no rvalid after write", {31'd0, cRv}, 32'd0);
  endtask

  task automatic testAbsent;
    tgtPresent = 1'b0;
    acc(1'b1, 1'b0, 2'd0, 2'd2, 0);
    chk(!cRd && cRv && cRdata == 32'h0, "R6 absent read zero", cRdata, 32'h0);
    acc(1'b1, 1'b1, 2'd0, 2'd2, 32'h1234);
    chk(!cWr, "R6 absent write dropped", {31'd0, cWr}, 32'd0);
    tgtPresent = 1'b1;
  endtask

  task automatic testDisabled;
    setAddr(32'h00123A08);
    acc(1'b1, 1'b0, 2'd0, 2'd2, 0);
    chk(!cRd && cRv && cRdata == 32'h0, "R3 disabled read zero", cRdata, 32'h0);
    acc(1'b1, 1'b1, 2'd1, 2'd0, 32'h77);
    chk(!cWr, "R3 disabled write dropped", {31'd0, cWr}, 32'd0);
  endtask

  task automatic testMisaligned;
    setAddr(32'h80123A09);
    acc(1'b1, 1'b0, 2'd0, 2'd2, 0);
    chk(!cRd && cRdata == 32'h0, "R4 misaligned read zero", cRdata, 32'h0);
    acc(1'b1, 1'b1, 2'd0, 2'd2, 32'h99);
    chk(!cWr, "R4 misaligned write dropped", {31'd0, cWr}, 32'd0);
    setAddr(32'h80123A0A);
    acc(1'b1, 1'b0, 2'd0, 2'd2, 0);
    chk(!cRd && cRdata == 32'h0, "R4 bit1 set read zero", cRdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testAddrPort();
    testDecode();
    testReads();
    testWrite();
    testAbsent();
    testDisabled();
    testMisaligned();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule